// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is the main counting engine of a general purpose timer. Four clock-enable inputs share the block's single synchronous clock. They stand for an external clock, an auxiliary clock, a sub-main clock and the inverted external clock. A source select picks one of them, and a power-of-two prescaler thins the chosen enable stream into count ticks. On each tick the counter moves according to the run mode: halted, up to a period value, free-running up to the maximum of the chosen counter length, or bouncing up to the period value and back down to zero.

The period arrives from outside as the channel-0 latch value. A single-cycle clear strobe returns the count, the prescaler phase and the direction to zero. Each wrap or return to zero sets a sticky rollover flag, and an enable gates that flag onto the interrupt request. Software clears the flag with its own strobe. The count and the current direction are outputs, so comparators and output units elsewhere in the timer can use them.

Top module: `mm_timer`

## Requirements
- R1: After reset, `count` is 0, `dir_down` is 0 and `irq` is 0.
- R2: With `mode_sel` = 10 (free-running), each tick adds 1 to `count`. The count wraps to 0 on the tick after it reaches the length maximum and sets the rollover flag. `len_sel` codes 00, 01, 10 and 11 give maxima of 0xFFFF, 0x0FFF, 0x03FF and 0x00FF.
- R3: With `mode_sel` = 01 (up), the count rises to top = min(`period`, length maximum). On the next tick it returns to 0 and sets the flag. A count already at or above top also wraps on the next tick.
- R4: With `mode_sel` = 11 (bounce), the count rises to top and then falls to 0, and repeats. `dir_down` is 1 from the tick that reaches top until the tick that reaches 0, and 0 otherwise. Reaching 0 while descending sets the flag.
- R5: `div_sel` codes 00, 01, 10 and 11 make one tick for every 1, 2, 4 and 8 enable pulses of the selected source. The tick falls on the last pulse of each group.
- R6: `src_sel` codes 00, 01, 10 and 11 select `ce_ext`, `ce_aux`, `ce_sub` and `ce_ext_inv`. Pulses on the other three inputs have no effect on the count.
- R7: A one-cycle `clr` strobe zeroes the count, the prescaler phase and `dir_down` at the next edge. It takes priority over a tick in the same cycle and leaves the flag unchanged.
- R8: With `mode_sel` = 00 (halt), enable pulses change neither the count nor the prescaler phase. Counting resumes from the held count and phase when a run mode returns.
- R9: `irq` is the flag AND `irq_en`. The flag stays set until a `flag_clr` strobe. If a flag-setting event and `flag_clr` arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all sources are enables in this domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_ext | input | 1 | External clock enable (source 00) |
| ce_aux | input | 1 | Auxiliary clock enable (source 01) |
| ce_sub | input | 1 | Sub-main clock enable (source 10) |
| ce_ext_inv | input | 1 | Inverted external clock enable (source 11) |
| src_sel | input | 2 | Clock source select |
| div_sel | input | 2 | Prescaler ratio select (1, 2, 4, 8) |
| len_sel | input | 2 | Counter length select (16, 12, 10, 8 bits) |
| mode_sel | input | 2 | Run mode: halt, up, free-running, bounce |
| period | input | 16 | Channel-0 latch value used as the top in up and bounce modes |
| clr | input | 1 | Clear strobe for count, prescaler and direction |
| flag_clr | input | 1 | Clears the rollover flag |
| irq_en | input | 1 | Gates the rollover flag onto `irq` |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while the bounce mode is descending |
| irq | output | 1 | Interrupt request |

## Verification
An enable pulse sampled at a rising edge moves `count`, `dir_down` and the flag at that same edge, so each result is due one edge after its stimulus. `irq` follows `irq_en` within the same cycle, with no register in between. The bench changes inputs on the falling edge and reads results on the next falling edge, so a burst of n pulses can be checked against the value expected after exactly n ticks. The tests set the prescaler phase with a known number of pulses before halt and clear, so that the one pulse where a held phase and a zeroed phase differ is the one that gets checked.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;

    typedef enum logic [1:0] {
        RUN_HALT   = 2'b00,
        RUN_UP     = 2'b01,
        RUN_FREE   = 2'b10,
        RUN_BOUNCE = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        LEN_FULL = 2'b00,
        LEN_M4   = 2'b01,
        LEN_M6   = 2'b10,
        LEN_M8   = 2'b11
    } len_code_e;

endpackage

// File: rtl/mm_timer_srcsel.sv
module mm_timer_srcsel #(
    parameter int NSRC = 4,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] ce_in,
    input  logic [SW-1:0]   sel,
    output logic            ce_out
);
    assign ce_out = ce_in[sel];
endmodule

// File: rtl/mm_timer_presc.sv
module mm_timer_presc #(
    parameter int PW = 3,
    localparam int DW = $clog2(PW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          run,
    input  logic          clr,
    input  logic [DW-1:0] div_sel,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } presc_st_t;

    presc_st_t st_q, st_d;
    logic [PW-1:0] mask;

    always_comb begin
        mask = ~({PW{1'b1}} << div_sel);
        st_d = st_q;
        tick = 1'b0;
        if (ce && run) begin
            tick       = ((st_q.phase & mask) == mask);
            st_d.phase = st_q.phase + 1'b1;
        end
        if (clr) begin
            st_d.phase = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CLR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.phase == '0)); // R7
    AST_HALT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(st_q.phase)); // R8
endmodule

// File: rtl/mm_timer_core.sv
module mm_timer_core
    import mm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic          flag_clr,
    input  logic [1:0]    mode_sel,
    input  logic [1:0]    len_sel,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] count,
    output logic          dir_down,
    output logic          flag
);
    localparam logic [CW-1:0] LMAX_FULL = {CW{1'b1}};
    localparam logic [CW-1:0] LMAX_M4   = LMAX_FULL >> 4;
    localparam logic [CW-1:0] LMAX_M6   = LMAX_FULL >> 6;
    localparam logic [CW-1:0] LMAX_M8   = LMAX_FULL >> 8;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
        logic          flag;
    } core_st_t;

    core_st_t      st_q, st_d;
    logic [CW-1:0] lmax, top, inc;
    logic          wrap;
    run_mode_e     mode;

    always_comb begin
        mode = run_mode_e'(mode_sel);
        unique case (len_code_e'(len_sel))
            LEN_FULL: lmax = LMAX_FULL;
            LEN_M4:   lmax = LMAX_M4;
            LEN_M6:   lmax = LMAX_M6;
            default:  lmax = LMAX_M8;
        endcase
        top  = (period > lmax) ? lmax : period;
        inc  = st_q.cnt + 1'b1;
        wrap = 1'b0;
        st_d = st_q;
        if (tick) begin
            unique case (mode)
                RUN_UP: begin
                    st_d.down = 1'b0;
                    if (st_q.cnt >= top) begin
                        st_d.cnt = '0;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = inc;
                    end
                end
                RUN_FREE: begin
                    st_d.down = 1'b0;
                    if (st_q.cnt >= lmax) begin
                        st_d.cnt = '0;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = inc;
                    end
                end
                RUN_BOUNCE: begin
                    if (!st_q.down && st_q.cnt < top) begin
                        st_d.cnt  = inc;
                        st_d.down = (inc >= top);
                    end else if (st_q.cnt != '0) begin
                        st_d.cnt  = st_q.cnt - 1'b1;
                        st_d.down = 1'b1;
                        if (st_q.cnt == {{(CW-1){1'b0}}, 1'b1}) begin
                            st_d.down = 1'b0;
                            wrap      = 1'b1;
                        end
                    end else begin
                        st_d.down = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (wrap)          st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign dir_down = st_q.down;
    assign flag     = st_q.flag;

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && mode == RUN_FREE && st_q.cnt < lmax)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R2
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && mode == RUN_UP && st_q.cnt >= top)
        |=> (st_q.cnt == '0 && st_q.flag)); // R3
    AST_BOUNCE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && mode == RUN_BOUNCE && st_q.cnt <= top)
        |=> (st_q.cnt <= $past(top))); // R4
    AST_CLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && !st_q.down)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(st_q.cnt)); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr) |=> st_q.flag); // R9
endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import mm_timer_pkg::*;
#(
    parameter int CW   = 16,
    parameter int PW   = 3,
    parameter int NSRC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_ext,
    input  logic          ce_aux,
    input  logic          ce_sub,
    input  logic          ce_ext_inv,
    input  logic [1:0]    src_sel,
    input  logic [1:0]    div_sel,
    input  logic [1:0]    len_sel,
    input  logic [1:0]    mode_sel,
    input  logic [CW-1:0] period,
    input  logic          clr,
    input  logic          flag_clr,
    input  logic          irq_en,
    output logic [CW-1:0] count,
    output logic          dir_down,
    output logic          irq
);
    logic ce_sel, tick, run, flag;

    assign run = (run_mode_e'(mode_sel) != RUN_HALT);

    mm_timer_srcsel #(.NSRC(NSRC)) u_src (
        .ce_in  ({ce_ext_inv, ce_sub, ce_aux, ce_ext}),
        .sel    (src_sel),
        .ce_out (ce_sel)
    );

    mm_timer_presc #(.PW(PW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce_sel),
        .run     (run),
        .clr     (clr),
        .div_sel (div_sel),
        .tick    (tick)
    );

    mm_timer_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (clr),
        .flag_clr (flag_clr),
        .mode_sel (mode_sel),
        .len_sel  (len_sel),
        .period   (period),
        .count    (count),
        .dir_down (dir_down),
        .flag     (flag)
    );

    assign irq = flag & irq_en;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R9
    AST_HALT_TICKLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count)); // R8
endmodule

// File: tb/mm_timer_test.sv
module mm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ce = '0;
    logic [1:0]  src_sel = 2'b00, div_sel = 2'b00, len_sel = 2'b00, mode_sel = 2'b00;
    logic [15:0] period = '0;
    logic        clr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
    logic [15:0] count;
    logic        dir_down, irq;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    mm_timer uut (
        .clk(clk), .rst_n(rst_n),
        .ce_ext(ce[0]), .ce_aux(ce[1]), .ce_sub(ce[2]), .ce_ext_inv(ce[3]),
        .src_sel(src_sel), .div_sel(div_sel), .len_sel(len_sel), .mode_sel(mode_sel),
        .period(period), .clr(clr), .flag_clr(flag_clr), .irq_en(irq_en),
        .count(count), .dir_down(dir_down), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            ce[idx] = 1'b1;
            @(negedge clk);
        end
        ce[idx] = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1; @(negedge clk); clr = 1'b0;
    endtask

    task automatic drop_flag();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic setup(input logic [1:0] m, input logic [1:0] l, input logic [1:0] d);
        mode_sel = m; len_sel = l; div_sel = d; src_sel = 2'b00;
        do_clear();
        drop_flag();
    endtask

    task automatic t_reset();
        check("R1 count", count, 0);
        check("R1 dir", dir_down, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_free();
        irq_en = 1'b1;
        setup(2'b10, 2'b11, 2'b00);
        run(0, 10);  check("R2 step", count, 10);
        run(0, 245); check("R2 at 8-bit max", count, 16'h00FF); check("R2 no flag", irq, 0);
        run(0, 1);   check("R2 8-bit wrap", count, 0); check("R2 flag", irq, 1);
        setup(2'b10, 2'b01, 2'b00);
        run(0, 4095); check("R2 at 12-bit max", count, 16'h0FFF);
        run(0, 1);    check("R2 12-bit wrap", count, 0);
        setup(2'b10, 2'b10, 2'b00);
        run(0, 1024); check("R2 10-bit wrap", count, 0);
        setup(2'b10, 2'b00, 2'b00);
        run(0, 65535); check("R2 at 16-bit max", count, 16'hFFFF); check("R2 16 no flag", irq, 0);
        run(0, 1);     check("R2 16-bit wrap", count, 0); check("R2 16 flag", irq, 1);
    endtask

    task automatic t_up();
        period = 16'd5;
        setup(2'b01, 2'b00, 2'b00);
        run(0, 5); check("R3 at top", count, 5); check("R3 no flag", irq, 0);
        run(0, 1); check("R3 wrap", count, 0); check("R3 flag", irq, 1);
        period = 16'h0300;
        setup(2'b01, 2'b11, 2'b00);
        run(0, 255); check("R3 clamp top", count, 16'h00FF);
        run(0, 1);   check("R3 clamp wrap", count, 0);
        setup(2'b10, 2'b00, 2'b00);
        run(0, 9); mode_sel = 2'b01; period = 16'd4; drop_flag();
        run(0, 1); check("R3 above top wraps", count, 0); check("R3 above top flag", irq, 1);
    endtask

    task automatic t_bounce();
        period = 16'd3;
        setup(2'b11, 2'b00, 2'b00);
        run(0, 3); check("R4 top", count, 3); check("R4 dir at top", dir_down, 1);
        run(0, 2); check("R4 falling", count, 1); check("R4 dir falling", dir_down, 1);
        check("R4 no flag yet", irq, 0);
        run(0, 1); check("R4 zero", count, 0); check("R4 dir at zero", dir_down, 0);
        check("R4 flag at zero", irq, 1);
        run(0, 1); check("R4 rising again", count, 1); check("R4 dir rising", dir_down, 0);
        run(0, 2); check("R7 pre-clear dir", dir_down, 1);
        do_clear();
        check("R7 clear count", count, 0); check("R7 clear dir", dir_down, 0);
        check("R7 flag kept", irq, 1);
    endtask

    task automatic t_div();
        setup(2'b10, 2'b00, 2'b01);
        run(0, 5); check("R5 div2", count, 2);
        setup(2'b10, 2'b00, 2'b10);
        run(0, 9); check("R5 div4", count, 2);
        setup(2'b10, 2'b00, 2'b11);
        run(0, 7); check("R5 div8 before", count, 0);
        run(0, 1); check("R5 div8 tick", count, 1);
    endtask

    task automatic t_src();
        setup(2'b10, 2'b00, 2'b00);
        run(1, 3); check("R6 aux ignored", count, 0);
        src_sel = 2'b01; run(1, 3); check("R6 aux", count, 3);
        src_sel = 2'b11; run(3, 2); check("R6 inverted ext", count, 5);
        run(0, 2); check("R6 ext ignored", count, 5);
        src_sel = 2'b10; run(2, 1); check("R6 sub", count, 6);
    endtask

    task automatic t_clear();
        setup(2'b10, 2'b00, 2'b11);
        run(0, 43); check("R7 pre-clear", count, 5);
        do_clear(); check("R7 count zero", count, 0);
        run(0, 7); check("R7 phase reset", count, 0);
        run(0, 1); check("R7 phase tick", count, 1);
        div_sel = 2'b00; run(0, 1);
        ce[0] = 1'b1; clr = 1'b1; @(negedge clk); ce[0] = 1'b0; clr = 1'b0;
        check("R7 clear beats tick", count, 0);
    endtask

    task automatic t_halt();
        setup(2'b10, 2'b00, 2'b01);
        run(0, 9); check("R8 before halt", count, 4);
        mode_sel = 2'b00;
        run(0, 10); check("R8 held", count, 4);
        mode_sel = 2'b10;
        run(0, 1); check("R8 phase held", count, 5);
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        setup(2'b10, 2'b11, 2'b00);
        run(0, 256); check("R9 masked", irq, 0);
        irq_en = 1'b1; #1; check("R9 unmasked", irq, 1);
        @(negedge clk);
        drop_flag(); check("R9 cleared", irq, 0);
        run(0, 255);
        ce[0] = 1'b1; flag_clr = 1'b1; @(negedge clk); ce[0] = 1'b0; flag_clr = 1'b0;
        check("R9 set wins", irq, 1);
        check("R9 wrap count", count, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_free();
        t_up();
        t_bounce();
        t_div();
        t_src();
        t_clear();
        t_halt();
        t_irq();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule